// File: doc/BRIEF.md
# Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year covering 2000 to 2099. An external prescaler supplies a one-cycle strobe once per second and a one-cycle strobe on each half-second. On each accepted strobe the block advances the whole chain by one second in a single clock cycle. It then compares the new time with three alarm bytes.

A host reads and writes through a flat byte-wide register port. Reads are combinational, so they always return a coherent snapshot, even in the cycle of an advance. A control register holds four bits. One selects BCD or plain binary for every byte the host sees. One selects 12-hour or 24-hour hours. One freezes the chain while the host loads a new time. One enables the alarm. After the freeze is released, the first advance waits for the next half-second strobe. From then on the chain advances on the one-second strobe.

Top module: `tod_calendar`

## Requirements
- R1: After reset the time is 00:00:00, day of week 1, date 1, month 1, year 0, and the control byte reads 0x01 (freeze set, BCD, 12-hour, alarm off). The hours byte then reads 0x12, which is 12 AM.
- R2: Control bit 1 selects the byte format: 1 is plain binary, 0 is packed BCD. All time, calendar and alarm bytes are read and written in the selected format. For example, 15 seconds reads 0x15 in BCD and 0x0F in binary.
- R3: Control bit 2 set to 1 gives 24-hour hours (0–23). Cleared, it gives 12-hour hours in the order 12, 1, …, 11, with bit 7 of the hours byte meaning PM. PM flips when the hour moves from 11 to 12, and 11 PM rolls over to 12 AM.
- R4: While control bit 0 (freeze) is 1, neither strobe changes any time or calendar field.
- R5: After freeze goes from 1 to 0, one-second strobes are ignored until the first half-second strobe. That strobe advances the time once. After it, only one-second strobes advance the time.
- R6: Seconds and minutes wrap 59→0, and each wrap carries into the next field. Hours wrap at the end of the day. The end of a day steps the day of week 1..7 (7 wraps to 1) and the date.
- R7: February has 29 days when the year is divisible by 4 and 28 days otherwise. April, June, September and November have 30 days, and the other months have 31. December 31 rolls to January 1 of the next year, and year 99 rolls to 0.
- R8: A host write that lands in the same cycle as an advance sets the written field to the written value. All other fields advance normally.
- R9: When control bit 3 is 1, alarm_hit pulses for exactly one cycle, two clock edges after the strobe edge. It pulses only if each alarm byte (address 7 seconds, 8 minutes, 9 hours) either equals the new time byte in the current format or has its top two bits both 1.
- R10: Addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7–9 alarm, and 10 control. Other addresses read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1s | input | 1 | One-cycle strobe once per second |
| tick_half | input | 1 | One-cycle strobe each half-second |
| wr_en | input | 1 | Host write enable |
| addr | input | 4 | Register address, used for reads and writes |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Combinational read data for addr |
| alarm_hit | output | 1 | One-cycle alarm pulse |

## Verification
A wrong carry or month-length decision stays hidden until the chain crosses that boundary. So the vectors load a time one second before each rollover (minute, day, month, leap and non-leap February, century) and read every field right after a single advance. A bad carry then shows on the very next read. Format errors show immediately on readback, because each vector is loaded and read in its own format. Start-sequencing faults show as a field changing, or failing to change, on the first strobe after the freeze is released. Alarm faults show within two edges of the advance.

// File: rtl/tod_pkg.sv
// Package: shared widths, register addresses, the time record and the
// format conversion helpers. Assumes host-supplied values are valid.
package tod_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int N_ALM  = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC      = 4'd0,
        A_MIN      = 4'd1,
        A_HOUR     = 4'd2,
        A_DOW      = 4'd3,
        A_DATE     = 4'd4,
        A_MONTH    = 4'd5,
        A_YEAR     = 4'd6,
        A_ALM_SEC  = 4'd7,
        A_ALM_MIN  = 4'd8,
        A_ALM_HOUR = 4'd9,
        A_CTRL     = 4'd10
    } reg_addr_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [4:0] hour;    // always 0..23 internally
        logic [2:0] dow;
        logic [4:0] date;
        logic [3:0] month;
        logic [6:0] year;
    } tod_t;

    // Encode a binary value 0..99 as a host byte.
    function automatic logic [7:0] enc_byte(input logic [6:0] v, input logic bin);
        logic [6:0] t;
        logic [6:0] r;
        t = v / 7'd10;
        r = v - t * 7'd10;
        if (bin) return {1'b0, v};
        return {t[3:0], r[3:0]};
    endfunction

    // Decode a host byte into a binary value.
    function automatic logic [6:0] dec_byte(input logic [7:0] b, input logic bin);
        if (bin) return b[6:0];
        return {3'b0, b[7:4]} * 7'd10 + {3'b0, b[3:0]};
    endfunction

    // Hours byte as the host sees it, for either hour format.
    function automatic logic [7:0] hour_enc(input logic [4:0] h, input logic bin,
                                            input logic h24);
        logic [6:0] v;
        logic [7:0] e;
        if (h24) return enc_byte({2'b0, h}, bin);
        v = (h == 5'd0) ? 7'd12 : (h > 5'd12) ? {2'b0, h - 5'd12} : {2'b0, h};
        e = enc_byte(v, bin);
        return {(h >= 5'd12), e[6:0]};
    endfunction

    // Hours byte from the host into the internal 0..23 form.
    function automatic logic [4:0] hour_dec(input logic [7:0] b, input logic bin,
                                            input logic h24);
        logic [6:0] d;
        logic [4:0] base;
        if (h24) begin
            d = dec_byte(b, bin);
            return d[4:0];
        end
        d    = dec_byte({1'b0, b[6:0]}, bin);
        base = (d == 7'd12) ? 5'd0 : d[4:0];
        return base + (b[7] ? 5'd12 : 5'd0);
    endfunction

    // Days in a month; leap rule valid for years 2000..2099.
    function automatic logic [4:0] days_in(input logic [3:0] m, input logic [6:0] y);
        case (m)
            4'd2:                     return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            default:                  return 5'd31;
        endcase
    endfunction
endpackage

// File: rtl/tod_start.sv
// Advance gating: decides which strobe moves the chain. While frozen it
// arms a one-shot so that the first advance after release uses the
// half-second strobe. Assumes strobes are single-cycle pulses.
module tod_start (
    input  logic clk,
    input  logic rst_n,
    input  logic freeze,
    input  logic tick_1s,
    input  logic tick_half,
    output logic adv
);
    logic pend_q;

    // Arm while frozen; disarm on the first half-second strobe after release.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b1;
        else if (freeze)    pend_q <= 1'b1;
        else if (tick_half) pend_q <= 1'b0;
    end

    // Select the strobe that advances the chain this cycle.
    always_comb adv = !freeze && (pend_q ? tick_half : tick_1s);

    p_frozen_no_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> !adv);
    p_first_on_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && pend_q) |-> tick_half);
    p_disarm_after_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && pend_q) |=> (!pend_q || freeze));
endmodule

// File: rtl/tod_chain.sv
// Next-second function: purely combinational ripple of carries through
// seconds, minutes, hours, day of week, date, month and year. Assumes the
// incoming record holds valid values.
module tod_chain
    import tod_pkg::*;
#(
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_HOUR  = 60,
    parameter int HOURS_PER_DAY = 24,
    parameter int DAYS_PER_WK   = 7,
    parameter int MONTHS_PER_YR = 12,
    parameter int YEAR_SPAN     = 100
) (
    input  tod_t cur,
    output tod_t nxt
);
    localparam logic [6:0] SEC_LAST  = 7'(SEC_PER_MIN - 1);
    localparam logic [6:0] MIN_LAST  = 7'(MIN_PER_HOUR - 1);
    localparam logic [4:0] HOUR_LAST = 5'(HOURS_PER_DAY - 1);
    localparam logic [2:0] DOW_LAST  = 3'(DAYS_PER_WK);
    localparam logic [3:0] MON_LAST  = 4'(MONTHS_PER_YR);
    localparam logic [6:0] YEAR_LAST = 7'(YEAR_SPAN - 1);

    // Ripple the one-second increment through each field in turn.
    always_comb begin
        logic c;
        nxt = cur;
        c   = 1'b0;
        if (cur.sec == SEC_LAST) begin nxt.sec = '0; c = 1'b1; end
        else                           nxt.sec = cur.sec + 7'd1;
        if (c) begin
            c = 1'b0;
            if (cur.min == MIN_LAST) begin nxt.min = '0; c = 1'b1; end
            else                           nxt.min = cur.min + 7'd1;
        end
        if (c) begin
            c = 1'b0;
            if (cur.hour == HOUR_LAST) begin nxt.hour = '0; c = 1'b1; end
            else                             nxt.hour = cur.hour + 5'd1;
        end
        if (c) begin
            nxt.dow = (cur.dow == DOW_LAST) ? 3'd1 : cur.dow + 3'd1;
            c = 1'b0;
            if (cur.date == days_in(cur.month, cur.year)) begin nxt.date = 5'd1; c = 1'b1; end
            else                                                nxt.date = cur.date + 5'd1;
        end
        if (c) begin
            c = 1'b0;
            if (cur.month == MON_LAST) begin nxt.month = 4'd1; c = 1'b1; end
            else                             nxt.month = cur.month + 4'd1;
        end
        if (c) nxt.year = (cur.year == YEAR_LAST) ? '0 : cur.year + 7'd1;
    end
endmodule

// File: rtl/tod_alarm.sv
// Alarm comparator: one cycle after an advance, compares each alarm byte
// with the matching time byte (as the host sees it) and raises a one-cycle
// pulse. A byte with its top two bits set matches anything.
module tod_alarm
    import tod_pkg::*;
#(
    parameter int N = N_ALM,
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         adv,
    input  logic [N*W-1:0] cur_bytes,
    input  logic [N*W-1:0] alm_bytes,
    output logic         hit
);
    logic [N-1:0] match;
    logic         chk_q;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = (alm_bytes[i*W+W-1 -: 2] == 2'b11) ||
                          (alm_bytes[i*W +: W] == cur_bytes[i*W +: W]);
    end

    // Remember that an advance happened so the check sees the new time.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_q <= 1'b0;
        else        chk_q <= adv;
    end

    // Register the alarm decision as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= chk_q && en && (&match);
    end
endmodule

// File: rtl/tod_calendar.sv
// Top: holds the time record, control bits and alarm bytes; converts
// between the internal binary record and the host byte format; merges
// host writes with the chain advance (a write wins for its own field).
// Assumes the host writes only valid values in the current format.
module tod_calendar
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s,
    input  logic              tick_half,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              alarm_hit
);
    localparam tod_t TOD_RESET = '{sec: 7'd0, min: 7'd0, hour: 5'd0, dow: 3'd1,
                                   date: 5'd1, month: 4'd1, year: 7'd0};

    tod_t tq, chain_nxt, tn;
    logic freeze_q, bin_q, h24_q, aen_q;
    logic [N_ALM*DATA_W-1:0] alm_q;
    logic [N_ALM*DATA_W-1:0] cur_bytes;
    logic adv;
    logic [6:0] wv;

    tod_start u_start (
        .clk(clk), .rst_n(rst_n), .freeze(freeze_q),
        .tick_1s(tick_1s), .tick_half(tick_half), .adv(adv)
    );

    tod_chain u_chain (.cur(tq), .nxt(chain_nxt));

    // Merge the advance with a host write; the written field takes priority.
    always_comb begin
        tn = adv ? chain_nxt : tq;
        wv = dec_byte(wr_data, bin_q);
        if (wr_en) begin
            case (addr)
                A_SEC:   tn.sec   = wv;
                A_MIN:   tn.min   = wv;
                A_HOUR:  tn.hour  = hour_dec(wr_data, bin_q, h24_q);
                A_DOW:   tn.dow   = wv[2:0];
                A_DATE:  tn.date  = wv[4:0];
                A_MONTH: tn.month = wv[3:0];
                A_YEAR:  tn.year  = wv;
                default: ;
            endcase
        end
    end

    // Time record register.
    always_ff @(posedge clk) begin
        if (!rst_n) tq <= TOD_RESET;
        else        tq <= tn;
    end

    // Control and alarm byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {aen_q, h24_q, bin_q, freeze_q} <= 4'b0001;
            alm_q <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL:     {aen_q, h24_q, bin_q, freeze_q} <= wr_data[3:0];
                A_ALM_SEC:  alm_q[0*DATA_W +: DATA_W] <= wr_data;
                A_ALM_MIN:  alm_q[1*DATA_W +: DATA_W] <= wr_data;
                A_ALM_HOUR: alm_q[2*DATA_W +: DATA_W] <= wr_data;
                default: ;
            endcase
        end
    end

    // Time bytes in host format, used by the alarm compare.
    always_comb cur_bytes = {hour_enc(tq.hour, bin_q, h24_q),
                             enc_byte(tq.min, bin_q), enc_byte(tq.sec, bin_q)};

    // Combinational read mux.
    always_comb begin
        case (addr)
            A_SEC:      rd_data = enc_byte(tq.sec, bin_q);
            A_MIN:      rd_data = enc_byte(tq.min, bin_q);
            A_HOUR:     rd_data = hour_enc(tq.hour, bin_q, h24_q);
            A_DOW:      rd_data = enc_byte({4'b0, tq.dow}, bin_q);
            A_DATE:     rd_data = enc_byte({2'b0, tq.date}, bin_q);
            A_MONTH:    rd_data = enc_byte({3'b0, tq.month}, bin_q);
            A_YEAR:     rd_data = enc_byte(tq.year, bin_q);
            A_ALM_SEC:  rd_data = alm_q[0*DATA_W +: DATA_W];
            A_ALM_MIN:  rd_data = alm_q[1*DATA_W +: DATA_W];
            A_ALM_HOUR: rd_data = alm_q[2*DATA_W +: DATA_W];
            A_CTRL:     rd_data = {4'b0, aen_q, h24_q, bin_q, freeze_q};
            default:    rd_data = '0;
        endcase
    end

    tod_alarm u_alarm (
        .clk(clk), .rst_n(rst_n), .en(aen_q), .adv(adv),
        .cur_bytes(cur_bytes), .alm_bytes(alm_q), .hit(alarm_hit)
    );

    p_freeze_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_q && !wr_en) |=> $stable(tq));
    p_hour_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_en && tq.hour < 5'd24) |=> (tq.hour < 5'd24));
    p_month_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_en && tq.month >= 4'd1 && tq.month <= 4'd12)
        |=> (tq.month >= 4'd1 && tq.month <= 4'd12));
    p_sec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_en && tq.sec < 7'd60) |=> (tq.sec < 7'd60));
    p_alarm_after_adv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> $past(adv, 2));
endmodule

// File: tb/tod_calendar_tb.sv
module tod_calendar_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1s = 1'b0, tick_half = 1'b0, wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       alarm_hit;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    tod_calendar u_dut (.clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .tick_half(tick_half),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .alarm_hit(alarm_hit));

    // Vector: ctrl mode, start sec..year, expected sec..year after one advance.
    localparam logic [119:0] VEC [8] = '{
        {8'h00, 8'h59,8'h59,8'h91,8'h07,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h12,8'h01,8'h01,8'h01,8'h00},
        {8'h04, 8'h59,8'h59,8'h23,8'h03,8'h28,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h04,8'h29,8'h02,8'h24},
        {8'h04, 8'h59,8'h59,8'h23,8'h02,8'h28,8'h02,8'h23, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h03,8'h23},
        {8'h06, 8'h3B,8'h3B,8'h17,8'h05,8'h1E,8'h04,8'h63, 8'h00,8'h00,8'h00,8'h06,8'h01,8'h05,8'h63},
        {8'h02, 8'h3B,8'h3B,8'h0B,8'h01,8'h0F,8'h06,8'h05, 8'h00,8'h00,8'h8C,8'h01,8'h0F,8'h06,8'h05},
        {8'h00, 8'h59,8'h59,8'h92,8'h02,8'h10,8'h07,8'h10, 8'h00,8'h00,8'h81,8'h02,8'h10,8'h07,8'h10},
        {8'h04, 8'h09,8'h00,8'h00,8'h01,8'h01,8'h01,8'h01, 8'h10,8'h00,8'h00,8'h01,8'h01,8'h01,8'h01},
        {8'h04, 8'h59,8'h59,8'h23,8'h06,8'h29,8'h02,8'h00, 8'h00,8'h00,8'h00,8'h07,8'h01,8'h03,8'h00}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rd_data;
    endtask

    task automatic pulse(input logic half);
        @(negedge clk); if (half) tick_half = 1'b1; else tick_1s = 1'b1;
        @(negedge clk); tick_half = 1'b0; tick_1s = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_reg("R1 sec", 4'd0, 8'h00);
        expect_reg("R1 hour 12AM", 4'd2, 8'h12);
        expect_reg("R1 dow", 4'd3, 8'h01);
        expect_reg("R1 month", 4'd5, 8'h01);
        expect_reg("R1 ctrl", 4'd10, 8'h01);

        // Vector walk: R2 R3 R6 R7 (and R5 first advance on half strobe)
        for (int v = 0; v < 8; v++) begin
            logic [7:0] mode;
            mode = VEC[v][119:112];
            wr(4'd10, mode | 8'h01);
            for (int f = 0; f < 7; f++) wr(4'(f), VEC[v][111 - 8*f -: 8]);
            wr(4'd10, mode);
            pulse(1'b1);
            for (int f = 0; f < 7; f++) begin
                rd(4'(f), d);
                check($sformatf("R6/R7/R3/R2 vec%0d field%0d", v, f), d, VEC[v][55 - 8*f -: 8]);
            end
        end

        // R5 start sequencing (BCD, 24h)
        wr(4'd10, 8'h05);
        wr(4'd0, 8'h10);
        wr(4'd10, 8'h04);
        pulse(1'b0);
        expect_reg("R5 1s ignored before half", 4'd0, 8'h10);
        pulse(1'b1);
        expect_reg("R5 half advances", 4'd0, 8'h11);
        pulse(1'b1);
        expect_reg("R5 later half ignored", 4'd0, 8'h11);
        pulse(1'b0);
        expect_reg("R5 1s advances", 4'd0, 8'h12);

        // R4 freeze
        wr(4'd10, 8'h05);
        pulse(1'b0);
        pulse(1'b1);
        expect_reg("R4 frozen sec", 4'd0, 8'h12);
        wr(4'd10, 8'h04);
        pulse(1'b1);
        expect_reg("R4 release then half", 4'd0, 8'h13);

        // R8 write during advance
        @(negedge clk); wr_en = 1'b1; addr = 4'd1; wr_data = 8'h30; tick_1s = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick_1s = 1'b0;
        expect_reg("R8 written min", 4'd1, 8'h30);
        expect_reg("R8 sec advanced", 4'd0, 8'h14);

        // R9 alarm
        wr(4'd7, 8'h15); wr(4'd8, 8'hC0); wr(4'd9, 8'hFF);
        wr(4'd10, 8'h0C);
        pulse(1'b0);
        @(posedge clk); #1 check("R9 alarm pulse", {7'd0, alarm_hit}, 8'h01);
        @(posedge clk); #1 check("R9 alarm one cycle", {7'd0, alarm_hit}, 8'h00);
        pulse(1'b0);
        @(posedge clk); #1 check("R9 no match", {7'd0, alarm_hit}, 8'h00);
        wr(4'd10, 8'h04);
        wr(4'd0, 8'h14);
        pulse(1'b0);
        @(posedge clk); #1 check("R9 disabled", {7'd0, alarm_hit}, 8'h00);

        // R2 format switch and R3 hour format switch on stored time
        wr(4'd2, 8'h13);
        wr(4'd10, 8'h00);
        expect_reg("R3 13h as 1 PM", 4'd2, 8'h81);
        wr(4'd10, 8'h06);
        expect_reg("R2 binary sec", 4'd0, 8'h0F);
        wr(4'd10, 8'h04);

        // R10 unmapped address
        wr(4'd12, 8'hAA);
        expect_reg("R10 unmapped reads zero", 4'd12, 8'h00);
        expect_reg("R10 ctrl unchanged", 4'd10, 8'h04);
        expect_reg("R10 sec unchanged", 4'd0, 8'h15);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule